// File: doc/BRIEF.md
# Serial Character Transmitter with Break and Interrupt Modes

This block turns bytes into asynchronous serial frames on a single output line. Each frame has one start bit, eight data bits sent least significant bit first, and one stop bit. A four-entry holding queue sits in front of the frame shifter. Software-side logic pushes characters through a write port and watches two flags: one for a full queue and one for a fully drained transmitter. The bit rate comes from an external tick. Each bit holds the line for exactly one tick interval, and the block starts a frame only on a tick.

Three control features are built around this path:
- A pulsed request queues a synchronization break. The break is a start bit, twelve low bits and a stop bit. The pending flag drops by itself when that frame ends.
- A polarity control inverts the line, so it idles low and every level is flipped.
- The interrupt output is a one-cycle pulse. A two-bit selector chooses its trigger: each character handed to the shifter, a handover that drains the queue, or the moment all transmission is finished. The fourth code is reserved and stays silent.

Dropping the enable cuts any frame short, flushes the queue and cancels a pending break.

Top module: `uart_tx_engine`

## Requirements
- R1: After reset, empty=1, full=0, irq=0, brk_pend=0, and txd equals the idle level (1 when inv=0).
- R2: A frame starts on a tick when tx_en=1, the shifter is free and a character is queued. It sends a 0 start bit, then the 8 data bits LSB first, then a 1 stop bit. Each bit lasts one tick interval. The next frame may start on the tick that ends the stop bit.
- R3: The queue holds 4 characters. full=1 exactly when 4 are held. A write while full is ignored, and so is a write while tx_en=0.
- R4: empty=1 exactly when the shifter is idle and the queue is empty. While empty=1 the line sits at its idle level.
- R5: A brk_set pulse while enabled sets brk_pend. The next frame to start is then a break: 13 consecutive 0 bits (start plus twelve) followed by a 1 stop bit. The break takes priority over queued data and does not consume a character. brk_pend clears on the tick that ends the break frame.
- R6: With inv=1, the line idles at 0 and every transmitted level is inverted.
- R7: While tx_en=0, txd is at the idle level in the same cycle. One cycle after tx_en falls, the queue is flushed (empty=1, full=0), any frame in progress is lost and brk_pend=0.
- R8: irq_mode=2'b00: one irq pulse for each character moved from the queue into the shifter. Break frames give no pulse.
- R9: irq_mode=2'b10: one irq pulse when a move into the shifter leaves the queue empty.
- R10: irq_mode=2'b01: one irq pulse when empty goes from 0 to 1 while enabled. An abort gives no pulse.
- R11: irq_mode=2'b11 never pulses. irq is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle bit-rate strobe |
| tx_en | input | 1 | Transmitter enable; low aborts and flushes |
| brk_set | input | 1 | Pulse to queue a synchronization break |
| inv | input | 1 | Line polarity inversion |
| irq_mode | input | 2 | Interrupt trigger select |
| wr_en | input | 1 | Character write strobe |
| wr_data | input | 8 | Character to queue |
| full | output | 1 | Queue cannot accept another character |
| empty | output | 1 | Shifter idle and queue empty |
| brk_pend | output | 1 | Break request not yet completed |
| txd | output | 1 | Serial line |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
A wrong read pointer or count shows up on the line within one frame (ten ticks), as a wrong or repeated byte. It also shows in the full and empty flags right after a burst of writes. A shifter bit counter that is off by one shows as a framing fault that the bench's line decoder sees at the stop position of the damaged frame. A wrong break length shows as a run of zeros other than thirteen. Trigger logic for the interrupt modes that misfires shows up as a pulse count per burst that differs from the expected value for the selected mode. That count is known as soon as the burst drains.

// File: rtl/uart_tx_engine.sv
module uart_tx_engine #(
  parameter int DW      = 8,
  parameter int DEPTH   = 4,
  parameter int BRK_LEN = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          tx_en,
  input  logic          brk_set,
  input  logic          inv,
  input  logic [1:0]    irq_mode,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          full,
  output logic          empty,
  output logic          brk_pend,
  output logic          txd,
  output logic          irq
);

  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int DFRM = DW + 2;
  localparam int BFRM = BRK_LEN + 2;
  localparam int SW   = (DFRM > BFRM) ? DFRM : BFRM;
  localparam int NW   = $clog2(SW + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt, cnt_n;
  logic          busy, busy_n, in_brk, brk_q, irq_q;
  logic [SW-1:0] sh, dfrm, bfrm;
  logic [NW-1:0] bits;

  logic wr_ok, last_bit, slot_free, ld_brk, ld_data, empty_n, ev;

  assign wr_ok     = tx_en && wr_en && (cnt != CW'(DEPTH));
  assign last_bit  = busy && baud_tick && (bits == NW'(1));
  assign slot_free = !busy || last_bit;
  assign ld_brk    = tx_en && baud_tick && slot_free && brk_q && !(busy && in_brk);
  assign ld_data   = tx_en && baud_tick && slot_free && !ld_brk && (cnt != '0);
  assign cnt_n     = tx_en ? (cnt + CW'(wr_ok) - CW'(ld_data)) : '0;
  assign busy_n    = tx_en && (ld_brk || ld_data || (busy && !last_bit));
  assign empty_n   = !busy_n && (cnt_n == '0);

  always_comb begin
    dfrm          = '1;
    dfrm[0]       = 1'b0;
    dfrm[DW:1]    = mem[rptr];
    bfrm          = '1;
    bfrm[BRK_LEN:0] = '0;
  end

  always_comb begin
    case (irq_mode)
      2'b00:   ev = ld_data;
      2'b10:   ev = ld_data && (cnt_n == '0);
      2'b01:   ev = tx_en && !empty && empty_n;
      default: ev = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (!tx_en) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      cnt <= cnt_n;
      if (wr_ok)   wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      if (ld_data) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      in_brk <= 1'b0;
      sh     <= '1;
      bits   <= '0;
    end else begin
      busy <= busy_n;
      if (ld_brk) begin
        sh     <= bfrm;
        bits   <= NW'(BFRM);
        in_brk <= 1'b1;
      end else if (ld_data) begin
        sh     <= dfrm;
        bits   <= NW'(DFRM);
        in_brk <= 1'b0;
      end else if (busy && baud_tick) begin
        sh   <= {1'b1, sh[SW-1:1]};
        bits <= bits - NW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                brk_q <= 1'b0;
    else if (!tx_en)           brk_q <= 1'b0;
    else if (brk_set)          brk_q <= 1'b1;
    else if (last_bit && in_brk) brk_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= ev;
  end

  assign full     = (cnt == CW'(DEPTH));
  assign empty    = !busy && (cnt == '0);
  assign brk_pend = brk_q;
  assign irq      = irq_q;
  assign txd      = ((tx_en && busy) ? sh[0] : 1'b1) ^ inv;

  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && tx_en && !ld_data) |=> full);
  p_empty_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (txd == !inv));
  p_brk_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(brk_pend) |-> ($past(!tx_en) || $past(baud_tick)));
  p_off_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> (txd == !inv));
  p_off_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (empty && !full && !brk_pend));
  p_irq_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  p_irq_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(irq_mode) != 2'b11));

endmodule

// File: tb/uart_tx_engine_bench.sv
module uart_tx_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 8;

  logic clk = 0, rst_n = 0, baud_tick = 0, tx_en = 0, brk_set = 0, inv = 0, wr_en = 0;
  logic [1:0] irq_mode = 0;
  logic [7:0] wr_data = 0;
  logic full, empty, brk_pend, txd, irq;

  uart_tx_engine u_uart_tx_engine (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en), .brk_set(brk_set),
    .inv(inv), .irq_mode(irq_mode), .wr_en(wr_en), .wr_data(wr_data),
    .full(full), .empty(empty), .brk_pend(brk_pend), .txd(txd), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  bit gate = 0, done = 0;
  int irq_cnt = 0;
  int rxq[$];

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    int dc = 0;
    forever begin
      @(posedge clk); #1;
      dc = (dc + 1) % DIV;
      baud_tick = gate && (dc == 0);
    end
  end

  bit tick_pend = 0, irq_prev = 0;
  int dn = 0, zc = 0;
  logic [7:0] by;
  always @(negedge clk) begin
    logic v;
    if (irq) irq_cnt++;
    if (irq && irq_prev) chk(0, "R11 double pulse", 1, 0);
    irq_prev = irq;
    v = txd ^ inv;
    if (!tx_en) dn = 0;
    else if (tick_pend) begin
      if (dn == 0) begin
        if (!v) begin dn = 1; by = 0; end
      end else if (dn <= 8) begin
        by[dn-1] = v; dn++;
      end else if (dn == 9) begin
        if (v) begin rxq.push_back(by); dn = 0; end
        else begin dn = 10; zc = 10; end
      end else begin
        if (!v) zc++;
        else begin rxq.push_back(1000 + zc); dn = 0; end
      end
    end
    tick_pend = baud_tick;
  end

  task automatic put(logic [7:0] d);
    wr_en = 1; wr_data = d; step(1); wr_en = 0;
  endtask

  task automatic drain();
    int lim = 0;
    while (!(empty && dn == 0) && lim < 5000) begin step(1); lim++; end
    step(2 * DIV);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned s;
    logic [7:0] bytes[4];
    s = $urandom(32'h5EED);
    step(3);
    chk(empty === 1'b1, "R1 empty", empty, 1);
    chk(full === 1'b0, "R1 full", full, 0);
    chk(irq === 1'b0, "R1 irq", irq, 0);
    chk(brk_pend === 1'b0, "R1 brk_pend", brk_pend, 0);
    chk(txd === 1'b1, "R1 txd", txd, 1);
    rst_n = 1; tx_en = 1; step(2);

    // R3: fill, overflow ignored
    gate = 0; irq_mode = 2'b00; irq_cnt = 0; rxq.delete();
    put(8'h11); put(8'h22); put(8'h33);
    chk(full === 1'b0, "R3 not full at 3", full, 0);
    chk(empty === 1'b0, "R4 empty low with data", empty, 0);
    put(8'h44);
    chk(full === 1'b1, "R3 full at 4", full, 1);
    put(8'h55);
    chk(full === 1'b1, "R3 full after ignored write", full, 1);
    gate = 1; drain();
    chk(rxq.size() == 4, "R3 byte count", rxq.size(), 4);
    if (rxq.size() == 4) begin
      chk(rxq[0] == 8'h11, "R2 byte0", rxq[0], 8'h11);
      chk(rxq[3] == 8'h44, "R3 last kept byte", rxq[3], 8'h44);
    end
    chk(irq_cnt == 4, "R8 mode00 count", irq_cnt, 4);
    chk(empty === 1'b1, "R4 empty after drain", empty, 1);

    // R6: inverted idle
    inv = 1; step(2);
    chk(txd === 1'b0, "R6 inverted idle", txd, 0);
    inv = 0; step(2);

    // R5: break then data
    gate = 0; irq_mode = 2'b00; irq_cnt = 0; rxq.delete();
    brk_set = 1; step(1); brk_set = 0;
    chk(brk_pend === 1'b1, "R5 pending set", brk_pend, 1);
    put(8'hA5);
    gate = 1; drain();
    chk(rxq.size() == 2, "R5 frame count", rxq.size(), 2);
    if (rxq.size() == 2) begin
      chk(rxq[0] == 1013, "R5 break zeros", rxq[0] - 1000, 13);
      chk(rxq[1] == 8'hA5, "R5 data after break", rxq[1], 8'hA5);
    end
    chk(brk_pend === 1'b0, "R5 pending cleared", brk_pend, 0);
    chk(irq_cnt == 1, "R8 break gives no pulse", irq_cnt, 1);

    // R7 + R10: abort mid frame, no irq
    gate = 0; irq_mode = 2'b01; irq_cnt = 0; rxq.delete();
    put(8'h0F); put(8'hF0); put(8'h3C);
    brk_set = 1; step(1); brk_set = 0;
    gate = 1; step(5 * DIV);
    tx_en = 0; #1;
    chk(txd === 1'b1, "R7 idle on disable", txd, 1);
    step(1);
    chk(empty === 1'b1, "R7 flushed empty", empty, 1);
    chk(full === 1'b0, "R7 flushed full", full, 0);
    chk(brk_pend === 1'b0, "R7 break dropped", brk_pend, 0);
    put(8'h77); put(8'h78);
    tx_en = 1; step(30 * DIV);
    chk(rxq.size() == 0, "R3 write while disabled ignored", rxq.size(), 0);
    chk(empty === 1'b1, "R7 still empty", empty, 1);
    chk(irq_cnt == 0, "R10 abort no pulse", irq_cnt, 0);

    // random bursts: R2 R6 R8 R9 R10 R11
    for (int it = 0; it < 14; it++) begin
      int n, m, exp_irq;
      m = $urandom % 4; n = 1 + $urandom % 4;
      gate = 0; irq_mode = 2'(m); inv = 1'($urandom % 2);
      step(2); irq_cnt = 0; rxq.delete();
      for (int k = 0; k < n; k++) begin bytes[k] = 8'($urandom); put(bytes[k]); end
      gate = 1; drain();
      exp_irq = (m == 0) ? n : (m == 3) ? 0 : 1;
      chk(rxq.size() == n, "R2 random frame count", rxq.size(), n);
      for (int k = 0; k < n && k < rxq.size(); k++)
        chk(rxq[k] == bytes[k], inv ? "R6 inverted data" : "R2 data", rxq[k], bytes[k]);
      chk(irq_cnt == exp_irq, m == 0 ? "R8 pulses" : m == 2 ? "R9 pulses" :
          m == 1 ? "R10 pulses" : "R11 reserved pulses", irq_cnt, exp_irq);
      chk(txd === !inv, "R4 idle after burst", txd, !inv);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule